// File: doc/BRIEF.md
# Flash Write Latch Loader

This block sits between a simple bus port and the page data latch of a page-programmed non-volatile array. Software writes 32-bit words into the flash address range. The block gathers them, four at a time, into a 128-bit flash word. When the last word of a group (byte offset 0xC inside the group) is written, the whole flash word moves into the matching row of a 512-byte page latch. A control register can also force a load of a partly written group. Slots that were never written load as all ones, so those cells are left untouched when the page is programmed.

The same control register can flood the whole page latch with ones, and it can switch flash-range reads to return page latch contents. The block records the page number of the most recent flash-range write, which a programming sequencer uses as the target page. Every bus access takes two cycles: the ready output stays low in the first cycle and goes high in the second.

Top module: `flash_wlatch_loader`

## Requirements
- R1: For every access, `bus_ready` is low in the first cycle that `bus_sel` is high and high in the second, and the access completes in that second cycle.
- R2: A completed write with `bus_addr[ADDR_W-1]`=0 is a flash write. Address bits [3:2] choose the word slot (0..3) within the pending flash word, and bits [8:4] choose the page latch row (0..31).
- R3: A flash write to slot 3 loads all four pending slots into the latch row named by that write. The load happens in the cycle after the write completes, with slot n in bits [32n+31:32n].
- R4: Flash writes to slots 0 to 2 alone leave the page latch unchanged.
- R5: A control write (`bus_addr[ADDR_W-1]`=1) with data bit 1 set loads the pending flash word into the row of the most recent flash write, with unwritten slots as all ones. Bit 1 clears itself and reads back as 0.
- R6: After each load, every slot of the pending flash word returns to all ones.
- R7: While control bit 0 is set, every page latch row and every pending slot is held at all ones, and pending flash writes are discarded. Clearing the bit releases the latch.
- R8: With control bit 2 set, a flash-range read returns the latch word at row [8:4], slot [3:2]. With it clear, flash reads return 0. A control read returns {bit2, bit1, bit0} in bits [2:0].
- R9: `page_addr` equals `bus_addr[ADDR_W-2:9]` of the most recent completed flash write. Control writes and reads leave it unchanged.
- R10: After reset, the latch and the pending word hold all ones, the control bits are 0, `page_addr` is 0 and `bus_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request, held until ready |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; top bit selects the control register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while ready is high |
| bus_ready | output | 1 | High in the completing cycle of an access |
| page_addr | output | ADDR_W-10 | Page number of the last flash write |

## Verification
The bench uses the default ADDR_W of 18, which gives 256 pages of 32 latch rows each. That size lets the directed tests reach both the first row and the last row (31) of the latch, as well as the top page number 0xFF, without long runs. Because the geometry is small, a preset can be checked on rows at both ends.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
  localparam int WORD_W     = 32;
  localparam int SLOTS      = 4;
  localparam int FW_W       = WORD_W * SLOTS;
  localparam int PAGE_BYTES = 512;
  localparam int FW_BYTES   = FW_W / 8;
  localparam int NFW        = PAGE_BYTES / FW_BYTES;
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int FWI_W      = $clog2(NFW);
  localparam int BYTE_LSB   = $clog2(WORD_W / 8);
  localparam int PAGE_LSB   = $clog2(PAGE_BYTES);

  function automatic logic [SLOT_W-1:0] slot_of(input logic [31:0] a);
    return a[BYTE_LSB +: SLOT_W];
  endfunction

  function automatic logic [FWI_W-1:0] fword_of(input logic [31:0] a);
    return a[BYTE_LSB+SLOT_W +: FWI_W];
  endfunction

  function automatic logic [31:0] page_of(input logic [31:0] a);
    return a >> PAGE_LSB;
  endfunction

  function automatic logic [WORD_W-1:0] pick(input logic [FW_W-1:0] fw,
                                             input logic [SLOT_W-1:0] s);
    return fw[s*WORD_W +: WORD_W];
  endfunction
endpackage

// File: rtl/fwl_bus_wait.sv
module fwl_bus_wait (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  output logic ready
);
  logic wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= 1'b0;
    else        wait_q <= sel & ~wait_q;
  end

  assign ready = sel & wait_q;

  assert_wait_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !ready) |=> (!sel || ready));
  assert_single_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
endmodule

// File: rtl/fwl_collect.sv
module fwl_collect
  import fwl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] slot,
  input  logic [WORD_W-1:0] wdata,
  input  logic              clear,
  output logic [FW_W-1:0]   fw_data
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               word_q <= '1;
      else if (clear)                           word_q <= '1;
      else if (wr_en && slot == SLOT_W'(g))     word_q <= wdata;
    end
    assign fw_data[g*WORD_W +: WORD_W] = word_q;
  end

  assert_clear_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (fw_data == '1));
endmodule

// File: rtl/fwl_page_latch.sv
module fwl_page_latch
  import fwl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preset,
  input  logic              load,
  input  logic [FWI_W-1:0]  ld_idx,
  input  logic [FW_W-1:0]   ld_data,
  input  logic [FWI_W-1:0]  rd_idx,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [WORD_W-1:0] rd_word
);
  logic [FW_W-1:0] row [NFW];

  for (genvar g = 0; g < NFW; g++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              row[g] <= '1;
      else if (preset)                         row[g] <= '1;
      else if (load && ld_idx == FWI_W'(g))    row[g] <= ld_data;
    end
  end

  assign rd_word = pick(row[rd_idx], rd_slot);

  assert_preset_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> (row[0] == '1 && row[NFW-1] == '1));
  assert_load_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !preset) |=> (row[$past(ld_idx)] == $past(ld_data)));
endmodule

// File: rtl/flash_wlatch_loader.sv
module flash_wlatch_loader
  import fwl_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [WORD_W-1:0]       bus_wdata,
  output logic [WORD_W-1:0]       bus_rdata,
  output logic                    bus_ready,
  output logic [ADDR_W-2-PAGE_LSB:0] page_addr
);
  localparam int PG_W      = ADDR_W - 1 - PAGE_LSB;
  localparam int CB_PRESET = 0;
  localparam int CB_LOAD   = 1;
  localparam int CB_RB     = 2;

  logic [31:0]       addr32;
  logic              is_flash, wr_done, flash_wr, ctrl_wr;
  logic              auto_evt, man_evt;
  logic              preset_q, rb_q, load_go;
  logic [FWI_W-1:0]  fw_idx;
  logic [PG_W-1:0]   page_q;
  logic [FW_W-1:0]   fw_data;
  logic [WORD_W-1:0] rd_word;

  assign addr32   = {{(32-ADDR_W){1'b0}}, bus_addr};
  assign is_flash = ~bus_addr[ADDR_W-1];
  assign wr_done  = bus_sel & bus_ready & bus_wr;
  assign flash_wr = wr_done & is_flash;
  assign ctrl_wr  = wr_done & ~is_flash;
  assign auto_evt = flash_wr && (slot_of(addr32) == SLOT_W'(SLOTS-1));
  assign man_evt  = ctrl_wr & bus_wdata[CB_LOAD];

  fwl_bus_wait u_wait (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .ready(bus_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q <= 1'b0;
      rb_q     <= 1'b0;
      load_go  <= 1'b0;
      fw_idx   <= '0;
      page_q   <= '0;
    end else begin
      load_go <= auto_evt | man_evt;
      if (ctrl_wr) begin
        preset_q <= bus_wdata[CB_PRESET];
        rb_q     <= bus_wdata[CB_RB];
      end
      if (flash_wr) begin
        fw_idx <= fword_of(addr32);
        page_q <= PG_W'(page_of(addr32));
      end
    end
  end

  fwl_collect u_collect (
    .clk(clk), .rst_n(rst_n), .wr_en(flash_wr), .slot(slot_of(addr32)),
    .wdata(bus_wdata), .clear(load_go | preset_q), .fw_data(fw_data)
  );

  fwl_page_latch u_latch (
    .clk(clk), .rst_n(rst_n), .preset(preset_q), .load(load_go),
    .ld_idx(fw_idx), .ld_data(fw_data), .rd_idx(fword_of(addr32)),
    .rd_slot(slot_of(addr32)), .rd_word(rd_word)
  );

  always_comb begin
    if (is_flash) bus_rdata = rb_q ? rd_word : '0;
    else          bus_rdata = {{(WORD_W-3){1'b0}}, rb_q, load_go, preset_q};
  end

  assign page_addr = page_q;

  assert_page_track_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flash_wr |=> (page_addr == PG_W'(page_of($past(addr32)))));
  assert_page_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_wr |=> $stable(page_addr));
  assert_load_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> !load_go);
endmodule

// File: tb/flash_wlatch_loader_bench.sv
module flash_wlatch_loader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [17:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [7:0]  page_addr;

  int tests = 0, fails = 0, ready_bad = 0;
  logic [31:0] q;
  localparam logic [17:0] CTRL = 18'h20000;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  always #5 clk = ~clk;

  flash_wlatch_loader u_flash_wlatch_loader (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .page_addr(page_addr)
  );

  function automatic logic [17:0] fa(input int pg, input int fw, input int sl);
    return {1'b0, 8'(pg), 5'(fw), 2'(sl), 2'b00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [17:0] a, input logic [31:0] d,
                     output logic [31:0] r);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1;
    if (bus_ready !== 1'b0) ready_bad++;
    @(negedge clk);
    if (bus_ready !== 1'b1) ready_bad++;
    r = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [17:0] a, input logic [31:0] d);
    logic [31:0] unused;
    acc(1'b1, a, d, unused);
  endtask

  task automatic rd(input logic [17:0] a, output logic [31:0] r);
    acc(1'b0, a, 32'h0, r);
  endtask

  task automatic t_reset;
    chk("R10 ready", {31'b0, bus_ready}, 32'h0);
    chk("R10 page_addr", {24'b0, page_addr}, 32'h0);
    rd(CTRL, q); chk("R10 ctrl", q, 32'h0);
    wr(CTRL, 32'h4);
    rd(fa(0, 0, 0), q); chk("R10 latch ones", q, ONES);
    rd(fa(0, 31, 3), q); chk("R10 latch ones hi", q, ONES);
  endtask

  task automatic t_auto;
    for (int s = 0; s < 3; s++) wr(fa(3, 5, s), 32'hA000_0000 + s);
    rd(fa(3, 5, 0), q); chk("R4 no load before slot 3", q, ONES);
    wr(fa(3, 5, 3), 32'hA000_0003);
    for (int s = 0; s < 4; s++) begin
      rd(fa(3, 5, s), q); chk("R2 R3 auto load", q, 32'hA000_0000 + s);
    end
    chk("R9 page", {24'b0, page_addr}, 32'h3);
  endtask

  task automatic t_manual;
    wr(fa(4, 7, 1), 32'hB000_0001);
    wr(CTRL, 32'h6);
    rd(fa(4, 7, 0), q); chk("R5 unwritten slot0", q, ONES);
    rd(fa(4, 7, 1), q); chk("R5 written slot1", q, 32'hB000_0001);
    rd(fa(4, 7, 3), q); chk("R5 unwritten slot3", q, ONES);
    rd(CTRL, q); chk("R5 self clear", q, 32'h4);
  endtask

  task automatic t_bufreset;
    wr(fa(4, 9, 2), 32'hC000_0002);
    wr(CTRL, 32'h6);
    rd(fa(4, 9, 0), q); chk("R6 slot0 reset", q, ONES);
    rd(fa(4, 9, 1), q); chk("R6 slot1 reset", q, ONES);
    rd(fa(4, 9, 2), q); chk("R6 slot2 data", q, 32'hC000_0002);
    rd(fa(4, 9, 3), q); chk("R6 slot3 reset", q, ONES);
  endtask

  task automatic t_last;
    for (int s = 0; s < 4; s++) wr(fa(255, 31, s), 32'hE000_0000 + s);
    rd(fa(255, 31, 3), q); chk("R3 last row", q, 32'hE000_0003);
    rd(fa(255, 31, 0), q); chk("R3 last row slot0", q, 32'hE000_0000);
    chk("R9 top page", {24'b0, page_addr}, 32'hFF);
  endtask

  task automatic t_preset;
    wr(fa(6, 2, 1), 32'hD000_0001);
    wr(CTRL, 32'h5);
    wr(CTRL, 32'h4);
    rd(fa(6, 5, 0), q); chk("R7 row5 ones", q, ONES);
    rd(fa(6, 31, 3), q); chk("R7 row31 ones", q, ONES);
    rd(fa(6, 9, 2), q); chk("R7 row9 ones", q, ONES);
    wr(CTRL, 32'h6);
    rd(fa(6, 2, 1), q); chk("R7 pending cleared", q, ONES);
    wr(fa(6, 4, 3), 32'hF000_0003);
    rd(fa(6, 4, 3), q); chk("R7 released", q, 32'hF000_0003);
  endtask

  task automatic t_rboff;
    wr(CTRL, 32'h0);
    rd(fa(6, 4, 3), q); chk("R8 readback off", q, 32'h0);
    rd(CTRL, q); chk("R8 ctrl read", q, 32'h0);
    chk("R9 ctrl leaves page", {24'b0, page_addr}, 32'h6);
    chk("R1 wait state", ready_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre: begin end
    chk("R10 ready in reset", {31'b0, bus_ready}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_auto();
    t_manual();
    t_bufreset();
    t_last();
    t_preset();
    t_rboff();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule